// File: doc/BRIEF.md
# RGB to YCbCr 4:2:0 Converter

This block takes a raster stream of 8-bit RGB pixels and produces luma for every pixel plus one blue-difference and one red-difference chroma sample per 2x2 pixel group. Luma comes from a weighted sum of the three colour channels. Each chroma component is derived from the luma just computed: the colour channel minus luma, scaled, then shifted up by a mid-scale offset so that the result is non-negative. Chroma is then decimated by averaging the four values of each 2x2 group.

Pixels arrive with a valid strobe and a start-of-frame flag on the first pixel of a frame. The block tracks column and row itself, using a fixed line width set by a parameter. Luma leaves on its own valid strobe in input order. Chroma leaves on a second strobe once per group, together with the luma of the group's last pixel. One line buffer holds the horizontal pair sums of the even row until the odd row completes each group.

Top module: `rgb2ycc420`

## Requirements
- R1: Luma is Y = (77*R + 150*G + 29*B + 128) >> 8, that is, the weighted sum with coefficients in units of 1/256, rounded to nearest.
- R2: Per-pixel blue chroma is 128 + floor((144*(B - Y) + 128) / 256), where Y is the rounded luma of R1.
- R3: Per-pixel red chroma is 128 + floor((187*(R - Y) + 128) / 256), where Y is the rounded luma of R1.
- R4: Per-pixel chroma is clamped to the range 0 to 255. Saturated red gives red chroma 255 and saturated cyan gives red chroma 0.
- R5: Every accepted pixel produces exactly one luma output. It appears with y_valid_o exactly 3 clock cycles after the edge that accepts the pixel, and luma outputs keep input order.
- R6: c_valid_o is high only for pixels on an odd row and an odd column of the frame (counted from 0). It is never high in two consecutive cycles, and it is always high together with y_valid_o. A frame of FRAME_W x H pixels yields FRAME_W/2 * H/2 chroma outputs.
- R7: Each chroma output is (v00 + v01 + v10 + v11 + 2) >> 2, where the v are the per-pixel values (R2, R3, R4) of the four pixels at rows 2k and 2k+1 and columns 2m and 2m+1.
- R8: A pixel with sof_i high is placed at row 0, column 0, whatever position the previous pixels reached. Position counting starts again from it.
- R9: Cycles with pix_valid_i low do not advance the position and produce no output. y_o keeps its last value while y_valid_o is low.
- R10: While rst_ni is low, y_valid_o and c_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input pixel present this cycle |
| sof_i | input | 1 | Marks the first pixel of a frame |
| r_i | input | 8 | Red channel |
| g_i | input | 8 | Green channel |
| b_i | input | 8 | Blue channel |
| y_valid_o | output | 1 | Luma output valid |
| y_o | output | 8 | Luma |
| c_valid_o | output | 1 | Chroma pair valid, once per 2x2 group |
| cb_o | output | 8 | Averaged blue-difference chroma |
| cr_o | output | 8 | Averaged red-difference chroma |

## Verification
The hardest situation to reach is a start-of-frame that arrives while the internal position sits in the middle of an odd row. In that state the line buffer still holds stale even-row sums, and a wrong restart would pair chroma from the wrong pixels. The stimulus feeds one full row plus three pixels of an unrelated pattern, so that one group completes from that pattern, and then starts a fresh frame with the flag raised mid-line. Idle gaps of varying length are also inserted between pixels, so that pipeline advance and position counting are exercised apart from the clock.

// File: rtl/rgb2ycc_pkg.sv
package rgb2ycc_pkg;
  localparam int PIX_W = 8;

  localparam logic [7:0] KY_R  = 8'd77;
  localparam logic [7:0] KY_G  = 8'd150;
  localparam logic [7:0] KY_B  = 8'd29;
  localparam logic [7:0] K_CB  = 8'd144;
  localparam logic [7:0] K_CR  = 8'd187;

  // weights sum to 256, so the rounded result never exceeds 255
  function automatic logic [PIX_W-1:0] luma(input logic [PIX_W-1:0] r,
                                            input logic [PIX_W-1:0] g,
                                            input logic [PIX_W-1:0] b);
    logic [17:0] s;
    s = 18'(r) * 18'(KY_R) + 18'(g) * 18'(KY_G) + 18'(b) * 18'(KY_B) + 18'd128;
    return s[15:8];
  endfunction

  function automatic logic [PIX_W-1:0] chroma(input logic [7:0]       coef,
                                              input logic [PIX_W-1:0] v,
                                              input logic [PIX_W-1:0] y);
    logic signed [19:0] d;
    logic signed [19:0] t;
    d = $signed(20'(v)) - $signed(20'(y));
    t = d * $signed(20'(coef)) + 20'sd128;
    t = (t >>> 8) + 20'sd128;
    if (t < 20'sd0)        return '0;
    else if (t > 20'sd255) return '1;
    else                   return t[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/ycc_pos_track.sv
module ycc_pos_track #(
  parameter int FRAME_W = 8,
  localparam int COL_W  = $clog2(FRAME_W),
  localparam int HCOL_W = COL_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              sof_i,
  output logic              col_odd_o,
  output logic              row_odd_o,
  output logic [HCOL_W-1:0] hcol_o
);
  logic [COL_W-1:0] col_q, col_cur;
  logic             row_q, row_cur;

  assign col_cur = sof_i ? '0 : col_q;
  assign row_cur = sof_i ? 1'b0 : row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= 1'b0;
    end else if (vld_i) begin
      if (col_cur == COL_W'(FRAME_W - 1)) begin
        col_q <= '0;
        row_q <= ~row_cur;
      end else begin
        col_q <= col_cur + 1'b1;
        row_q <= row_cur;
      end
    end
  end

  assign col_odd_o = col_cur[0];
  assign row_odd_o = row_cur;
  assign hcol_o    = col_cur[COL_W-1:1];
endmodule

// File: rtl/ycc_matrix.sv
module ycc_matrix
  import rgb2ycc_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             vld_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] cb_o,
  output logic [PIX_W-1:0] cr_o
);
  logic             v1;
  logic [TAG_W-1:0] tag1;
  logic [PIX_W-1:0] y1, r1, b1;

  // stage 1: luma
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1   <= 1'b0;
      tag1 <= '0;
      y1   <= '0;
      r1   <= '0;
      b1   <= '0;
    end else begin
      v1 <= vld_i;
      if (vld_i) begin
        tag1 <= tag_i;
        y1   <= luma(r_i, g_i, b_i);
        r1   <= r_i;
        b1   <= b_i;
      end
    end
  end

  // stage 2: colour differences from registered luma
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      tag_o <= '0;
      y_o   <= '0;
      cb_o  <= '0;
      cr_o  <= '0;
    end else begin
      vld_o <= v1;
      if (v1) begin
        tag_o <= tag1;
        y_o   <= y1;
        cb_o  <= chroma(K_CB, b1, y1);
        cr_o  <= chroma(K_CR, r1, y1);
      end
    end
  end
endmodule

// File: rtl/ycc_chroma_decim.sv
module ycc_chroma_decim
  import rgb2ycc_pkg::*;
#(
  parameter int HALF_W = 4,
  parameter int HCOL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              col_odd_i,
  input  logic              row_odd_i,
  input  logic [HCOL_W-1:0] hcol_i,
  input  logic [PIX_W-1:0]  val_i,
  output logic [PIX_W-1:0]  avg_o
);
  logic [PIX_W-1:0] hold_q;
  logic [PIX_W:0]   line_q [HALF_W];
  logic [PIX_W:0]   pair;
  logic [PIX_W+1:0] quad;

  assign pair = {1'b0, hold_q} + {1'b0, val_i};
  assign quad = {1'b0, pair} + {1'b0, line_q[hcol_i]} + (PIX_W+2)'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      avg_o  <= '0;
    end else if (vld_i) begin
      if (!col_odd_i)     hold_q <= val_i;
      else if (row_odd_i) avg_o  <= quad[PIX_W+1:2];
    end
  end

  // even-row pair sums, no reset needed
  always_ff @(posedge clk_i) begin
    if (vld_i && col_odd_i && !row_odd_i) line_q[hcol_i] <= pair;
  end
endmodule

// File: rtl/rgb2ycc420.sv
module rgb2ycc420
  import rgb2ycc_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic             sof_i,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             y_valid_o,
  output logic [PIX_W-1:0] y_o,
  output logic             c_valid_o,
  output logic [PIX_W-1:0] cb_o,
  output logic [PIX_W-1:0] cr_o
);
  localparam int HALF_W = FRAME_W / 2;
  localparam int COL_W  = $clog2(FRAME_W);
  localparam int HCOL_W = COL_W - 1;
  localparam int TAG_W  = HCOL_W + 2;
  localparam int N_CH   = 2;

  logic              col_odd, row_odd;
  logic [HCOL_W-1:0] hcol;

  ycc_pos_track #(.FRAME_W(FRAME_W)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (pix_valid_i),
    .sof_i    (sof_i),
    .col_odd_o(col_odd),
    .row_odd_o(row_odd),
    .hcol_o   (hcol)
  );

  logic             v2;
  logic [TAG_W-1:0] tag2;
  logic [PIX_W-1:0] y2;
  logic [PIX_W-1:0] ch_in  [N_CH];
  logic [PIX_W-1:0] ch_out [N_CH];

  ycc_matrix #(.TAG_W(TAG_W)) u_mat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (pix_valid_i),
    .tag_i ({row_odd, col_odd, hcol}),
    .r_i   (r_i),
    .g_i   (g_i),
    .b_i   (b_i),
    .vld_o (v2),
    .tag_o (tag2),
    .y_o   (y2),
    .cb_o  (ch_in[0]),
    .cr_o  (ch_in[1])
  );

  logic              row_odd2, col_odd2;
  logic [HCOL_W-1:0] hcol2;
  assign {row_odd2, col_odd2, hcol2} = tag2;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    ycc_chroma_decim #(.HALF_W(HALF_W), .HCOL_W(HCOL_W)) u_dec (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .vld_i    (v2),
      .col_odd_i(col_odd2),
      .row_odd_i(row_odd2),
      .hcol_i   (hcol2),
      .val_i    (ch_in[ch]),
      .avg_o    (ch_out[ch])
    );
  end

  assign cb_o = ch_out[0];
  assign cr_o = ch_out[1];

  // stage 3: output registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_valid_o <= 1'b0;
      c_valid_o <= 1'b0;
      y_o       <= '0;
    end else begin
      y_valid_o <= v2;
      c_valid_o <= v2 & col_odd2 & row_odd2;
      if (v2) y_o <= y2;
    end
  end
endmodule

// File: rtl/rgb2ycc420_chk.sv
module rgb2ycc420_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pix_valid_i,
  input logic       sof_i,
  input logic       y_valid_o,
  input logic [7:0] y_o,
  input logic       c_valid_o
);
  // R5
  y_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o == $past(pix_valid_i, 3));

  // R6
  c_with_y_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |-> y_valid_o);

  // R6
  c_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_valid_o |=> !c_valid_o);

  // R8
  sof_no_chroma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && sof_i) |=> ##2 !c_valid_o);

  // R9
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_valid_o |-> $stable(y_o));

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!y_valid_o && !c_valid_o);
    end
  end
endmodule

bind rgb2ycc420 rgb2ycc420_chk u_chk (.*);

// File: tb/rgb2ycc420_test.sv
module rgb2ycc420_test;
  localparam int W    = 8;
  localparam int MAXN = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0, sof = 1'b0;
  logic [7:0] r = '0, g = '0, b = '0;
  logic       y_valid, c_valid;
  logic [7:0] y, cb, cr;

  always #10 clk = ~clk;

  rgb2ycc420 #(.FRAME_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .sof_i(sof),
    .r_i(r), .g_i(g), .b_i(b),
    .y_valid_o(y_valid), .y_o(y), .c_valid_o(c_valid), .cb_o(cb), .cr_o(cr)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int pr[MAXN], pg[MAXN], pb[MAXN], psof[MAXN], pgap[MAXN], pcyc[MAXN];
  int yq[$], ycq[$], cbq[$], crq[$], ccq[$];
  int last_y = 0;
  bit have_y = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor, also checks R9 hold while idle
  always @(negedge clk) begin
    if (rst_n) begin
      if (y_valid) begin
        yq.push_back(int'(y));
        ycq.push_back(cyc);
        last_y = int'(y);
        have_y = 1;
      end else if (have_y) begin
        chk(int'(y) == last_y, "R9 y hold", int'(y), last_y);
      end
      if (c_valid) begin
        cbq.push_back(int'(cb));
        crq.push_back(int'(cr));
        ccq.push_back(cyc);
      end
    end
  end

  function automatic int m_luma(int rr, int gg, int bb);
    return (77 * rr + 150 * gg + 29 * bb + 128) >>> 8;
  endfunction

  function automatic int m_chroma(int k, int v, int yy);
    int t;
    t = 128 + ((k * (v - yy) + 128) >>> 8);
    if (t < 0) t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_up();
  end

  // drive pixels 0..n-1 and compare every output to the model
  task automatic run(input int n, input string ry, input string rc);
    int ey[$], eyc[$], ecb[$], ecr[$], ecc[$];
    int cbv[2][W], crv[2][W];
    int col, row, yy;
    yq.delete(); ycq.delete(); cbq.delete(); crq.delete(); ccq.delete();
    for (int i = 0; i < n; i++) begin
      repeat (pgap[i]) begin
        @(negedge clk);
        pix_valid = 1'b0; sof = 1'b0;
      end
      @(negedge clk);
      pix_valid = 1'b1; sof = psof[i][0];
      r = 8'(pr[i]); g = 8'(pg[i]); b = 8'(pb[i]);
      pcyc[i] = cyc;
    end
    @(negedge clk);
    pix_valid = 1'b0; sof = 1'b0;
    repeat (6) @(negedge clk);
    col = 0; row = 0;
    for (int i = 0; i < n; i++) begin
      if (psof[i] != 0) begin col = 0; row = 0; end
      yy = m_luma(pr[i], pg[i], pb[i]);
      ey.push_back(yy);
      eyc.push_back(pcyc[i] + 3);
      cbv[row % 2][col] = m_chroma(144, pb[i], yy);
      crv[row % 2][col] = m_chroma(187, pr[i], yy);
      if (row % 2 == 1 && col % 2 == 1) begin
        ecb.push_back((cbv[0][col-1] + cbv[0][col] + cbv[1][col-1] + cbv[1][col] + 2) >>> 2);
        ecr.push_back((crv[0][col-1] + crv[0][col] + crv[1][col-1] + crv[1][col] + 2) >>> 2);
        ecc.push_back(pcyc[i] + 3);
      end
      if (col == W - 1) begin col = 0; row++; end
      else col++;
    end
    chk(yq.size() == ey.size(), "R5 luma count", yq.size(), ey.size());
    chk(cbq.size() == ecb.size(), "R6 chroma count", cbq.size(), ecb.size());
    foreach (ey[i]) if (i < yq.size()) begin
      chk(yq[i] == ey[i], ry, yq[i], ey[i]);
      chk(ycq[i] == eyc[i], "R5 luma cycle", ycq[i], eyc[i]);
    end
    foreach (ecb[i]) if (i < cbq.size()) begin
      chk(cbq[i] == ecb[i], {rc, " cb"}, cbq[i], ecb[i]);
      chk(crq[i] == ecr[i], {rc, " cr"}, crq[i], ecr[i]);
      chk(ccq[i] == ecc[i], "R6 chroma cycle", ccq[i], ecc[i]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!y_valid, "R10 y_valid in reset", int'(y_valid), 0);
    chk(!c_valid, "R10 c_valid in reset", int'(c_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!y_valid && !c_valid, "R10 idle after reset", int'(y_valid | c_valid), 0);
  endtask

  // gradient, 8x4: R1 R7 R6 R5
  task automatic t_ramp();
    for (int i = 0; i < W * 4; i++) begin
      pr[i] = ((i % W) * 32 + 5) % 256;
      pg[i] = (i / W) * 60 + 17;
      pb[i] = 255 - (i % W) * 30;
      psof[i] = (i == 0);
      pgap[i] = 0;
    end
    run(W * 4, "R1 ramp luma", "R7 ramp avg");
  endtask

  // uniform 2x2 groups of saturated colours: R2 R3 R4
  task automatic t_extremes();
    for (int i = 0; i < W * 4; i++) begin
      int k;
      k = ((i % W) / 2 + ((i / W) / 2) * 4) % 8;
      pr[i] = (k & 1) ? 255 : 0;
      pg[i] = (k & 2) ? 255 : 0;
      pb[i] = (k & 4) ? 255 : 0;
      psof[i] = (i == 0);
      pgap[i] = 0;
    end
    run(W * 4, "R1 R4 extreme luma", "R2 R3 R4 saturated chroma");
  endtask

  // pseudo-random pixels with idle gaps, 8x6: R9 R7
  task automatic t_gaps();
    int s;
    s = 32'h1ACE;
    for (int i = 0; i < W * 6; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7FFFFFFF;
      pr[i] = (s >> 4) & 255;
      pg[i] = (s >> 12) & 255;
      pb[i] = (s >> 20) & 255;
      psof[i] = (i == 0);
      pgap[i] = i % 3;
    end
    run(W * 6, "R9 R1 luma with gaps", "R9 R7 avg with gaps");
  endtask

  // stray row plus three pixels, then frame start mid odd row: R8
  task automatic t_sof();
    for (int i = 0; i < W + 3; i++) begin
      pr[i] = 250 - i * 7; pg[i] = i * 11; pb[i] = 40 + i * 13;
      psof[i] = (i == 0); pgap[i] = 0;
    end
    for (int i = 0; i < W * 4; i++) begin
      pr[W+3+i] = (i * 19) % 256; pg[W+3+i] = (200 + i * 5) % 256; pb[W+3+i] = (i * 41) % 256;
      psof[W+3+i] = (i == 0); pgap[W+3+i] = (i == 0) ? 2 : 0;
    end
    run(W * 4 + W + 3, "R8 luma after restart", "R8 R7 chroma after restart");
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_extremes();
    t_gaps();
    t_sof();
    finish_up();
  end
endmodule